// File: doc/BRIEF.md
# Split-Access Translation Outcome Tracker

This block follows one memory request that has been cut into several fragments, such as a load that straddles a page boundary. Each fragment is translated on its own and may finish in any order. For each fragment the translator returns a fault code, attribute flags and a physical address. The block files every result under the fragment's index. When the last fragment lands, it settles the request into one outcome: clean request, partial fault, full fault, or squashed.

The outcome carries the fault code exposed to the architecture, the merged attribute flags and the base physical address. It also says whether a memory access still has to be issued. A partial fault means the fragments before the first faulting fragment translated cleanly. In that case a load still reads memory for those leading fragments and defers the fault until the access completes. A store with a partial fault goes no further.

The memory-issue stage reports back through a return port. That return may carry a fault that overrides the stored one, or signal that the cache was blocked so the load must be replayed.

Top module: `split_xlate_agg`

## Requirements
- R1: A completion is stored in the slot named by its fragment index, whatever the arrival order; the outcome depends only on the set of results.
- R2: Each accepted completion lowers the in-translation count by one and raises the translated count by one; allocation sets them to the fragment count and zero.
- R3: Only fragments that translated with fault code 0 contribute their attribute flags, which are merged by bitwise OR.
- R4: A request squashed before or while translating ends in state code 5, exposes fault 0 and requests no memory access.
- R5: If fragment 0 faulted, the state is code 4 and the exposed fault is fragment 0's code; base address and flags read 0.
- R6: The outcome settles on the second rising edge after the last completion is sampled. With no faulting fragment the state is code 2 and the fault is 0. With the lowest faulting index above 0 the state is code 3, and the stored fault is that fragment's code.
- R7: When fragment 0 is clean, the base address is fragment 0's physical address and the merged flags are published.
- R8: A memory access is requested in state 2, or in state 3 for a load, until the access completes. A store in state 3 never requests one.
- R9: A conditional-swap request that ends in state 3 sets the error flag.
- R10: A non-zero fault returned by the memory-issue stage replaces the exposed fault. A zero return leaves the stored fault in place.
- R11: A load in state 3 whose access has not completed exposes fault 0 and asserts replay. The deferred fault appears once a non-blocked return arrives.
- R12: The error flag is set, and the completion or allocation ignored, in these cases: a completion while not translating, an index at or above the fragment count, a repeated index, or an allocation count of 0 or above NFRAG. Reset gives state 0 with counters and outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| alloc_valid | input | 1 | Start tracking a new request |
| alloc_nfrag | input | CNT_W | Fragment count, 1..NFRAG |
| alloc_is_load | input | 1 | 1 for load, 0 for store |
| alloc_cswap | input | 1 | Request is a conditional swap |
| squash | input | 1 | Kill the current request |
| done_valid | input | 1 | A fragment translation finished |
| done_idx | input | IDX_W | Fragment index of the completion |
| done_fault | input | FAULT_W | Fault code, 0 = none |
| done_flags | input | FLAG_W | Attribute flags of the fragment |
| done_paddr | input | PA_W | Physical address of the fragment |
| mem_ret_valid | input | 1 | Memory-issue stage reports back |
| mem_ret_fault | input | FAULT_W | Fault from the issue stage, 0 = none |
| mem_ret_blocked | input | 1 | Cache was blocked; access not complete |
| state_o | output | 3 | 0 idle, 1 translating, 2 request, 3 partial, 4 fault, 5 squashed |
| xlate_done | output | 1 | All fragments translated and outcome settled |
| fault_o | output | FAULT_W | Exposed fault code |
| mem_access_req | output | 1 | Memory access still to be issued |
| replay_o | output | 1 | Load must be re-executed later |
| base_paddr | output | PA_W | Base physical address |
| merged_flags | output | FLAG_W | Merged attribute flags |
| in_xlate_cnt | output | CNT_W | Fragments still translating |
| xlated_cnt | output | CNT_W | Fragments translated |
| err_o | output | 1 | Protocol error, cleared on allocation |

## Verification
The bench sweeps every fault mask for every fragment count up to four, for loads and stores. It delivers completions in both ascending and descending index order. A design that filed results by arrival order would show the wrong first fault when completions arrive in descending order. A design that merged flags from faulting fragments would publish bits that belong to no clean fragment. For partial-fault loads it first returns a blocked access and then a clean one. A design that dropped the deferred fault on a zero return, or raised it before completion, would expose the wrong code at one of those two points. Directed cases check that a store with a partial fault stays off the memory port, that a conditional swap ending in a partial fault sets the error flag, and that stray, repeated or out-of-range completions set the error flag without disturbing the counters.

// File: rtl/split_xlate_pkg.sv
package split_xlate_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_XLATE    = 3'd1,
    ST_REQUEST  = 3'd2,
    ST_PARTIAL  = 3'd3,
    ST_FAULT    = 3'd4,
    ST_SQUASHED = 3'd5
  } xs_state_e;

  function automatic logic is_outcome(xs_state_e s);
    return (s == ST_REQUEST) || (s == ST_PARTIAL) || (s == ST_FAULT);
  endfunction
endpackage

// File: rtl/frag_slot.sv
module frag_slot #(
  parameter int FAULT_W = 4,
  parameter int FLAG_W  = 4,
  parameter int PA_W    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               wr_en,
  input  logic [FAULT_W-1:0] fault_in,
  input  logic [FLAG_W-1:0]  flags_in,
  input  logic [PA_W-1:0]    pa_in,
  output logic               filled,
  output logic [FAULT_W-1:0] fault_q,
  output logic [FLAG_W-1:0]  flags_q,
  output logic [PA_W-1:0]    pa_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filled  <= 1'b0;
      fault_q <= '0;
      flags_q <= '0;
      pa_q    <= '0;
    end else if (clear) begin
      filled  <= 1'b0;
      fault_q <= '0;
      flags_q <= '0;
      pa_q    <= '0;
    end else if (wr_en) begin
      filled  <= 1'b1;
      fault_q <= fault_in;
      flags_q <= flags_in;
      pa_q    <= pa_in;
    end
  end

  // R1: a slot is written once per request
  assert_single_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear) |-> !filled);
endmodule

// File: rtl/fault_resolver.sv
module fault_resolver #(
  parameter int NFRAG   = 2,
  parameter int FAULT_W = 4,
  parameter int FLAG_W  = 4,
  parameter int IDX_W   = 1
) (
  input  logic [NFRAG-1:0]         filled,
  input  logic [NFRAG*FAULT_W-1:0] fault_vec,
  input  logic [NFRAG*FLAG_W-1:0]  flags_vec,
  output logic                     any_fault,
  output logic [IDX_W-1:0]         first_idx,
  output logic [FAULT_W-1:0]       first_code,
  output logic [FLAG_W-1:0]        clean_flags
);
  function automatic logic [NFRAG-1:0] fault_mask(logic [NFRAG*FAULT_W-1:0] fv);
    logic [NFRAG-1:0] m;
    for (int i = 0; i < NFRAG; i++) m[i] = (fv[i*FAULT_W +: FAULT_W] != '0);
    return m;
  endfunction

  function automatic logic [IDX_W-1:0] lowest_set(logic [NFRAG-1:0] m);
    logic [IDX_W-1:0] r = '0;
    for (int i = NFRAG - 1; i >= 0; i--) if (m[i]) r = IDX_W'(i);
    return r;
  endfunction

  logic [NFRAG-1:0] fmask;

  always_comb begin
    fmask       = fault_mask(fault_vec);
    any_fault   = |fmask;
    first_idx   = lowest_set(fmask);
    first_code  = fault_vec[first_idx*FAULT_W +: FAULT_W];
    clean_flags = '0;
    for (int i = 0; i < NFRAG; i++)
      if (filled[i] && !fmask[i]) clean_flags |= flags_vec[i*FLAG_W +: FLAG_W];
  end
endmodule

// File: rtl/split_xlate_agg.sv
module split_xlate_agg
  import split_xlate_pkg::*;
#(
  parameter int NFRAG   = 2,
  parameter int FAULT_W = 4,
  parameter int FLAG_W  = 4,
  parameter int PA_W    = 16,
  localparam int IDX_W  = (NFRAG > 1) ? $clog2(NFRAG) : 1,
  localparam int CNT_W  = $clog2(NFRAG + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  input  logic [CNT_W-1:0]   alloc_nfrag,
  input  logic               alloc_is_load,
  input  logic               alloc_cswap,
  input  logic               squash,
  input  logic               done_valid,
  input  logic [IDX_W-1:0]   done_idx,
  input  logic [FAULT_W-1:0] done_fault,
  input  logic [FLAG_W-1:0]  done_flags,
  input  logic [PA_W-1:0]    done_paddr,
  input  logic               mem_ret_valid,
  input  logic [FAULT_W-1:0] mem_ret_fault,
  input  logic               mem_ret_blocked,
  output logic [2:0]         state_o,
  output logic               xlate_done,
  output logic [FAULT_W-1:0] fault_o,
  output logic               mem_access_req,
  output logic               replay_o,
  output logic [PA_W-1:0]    base_paddr,
  output logic [FLAG_W-1:0]  merged_flags,
  output logic [CNT_W-1:0]   in_xlate_cnt,
  output logic [CNT_W-1:0]   xlated_cnt,
  output logic               err_o
);
  xs_state_e          state;
  logic [CNT_W-1:0]   nfrag_q;
  logic               is_load_q, cswap_q, squashed_q, fin_q, acc_done_q;
  logic [FAULT_W-1:0] fault_q;

  // named internal events
  logic alloc_ok, alloc_bad, done_ok, done_bad, last_done, resolve_ev, mem_ret_ev;

  logic [NFRAG-1:0]         slot_filled;
  logic [NFRAG*FAULT_W-1:0] slot_fault;
  logic [NFRAG*FLAG_W-1:0]  slot_flags;
  logic [NFRAG*PA_W-1:0]    slot_pa;
  logic                     any_fault;
  logic [IDX_W-1:0]         first_idx;
  logic [FAULT_W-1:0]       first_code;
  logic [FLAG_W-1:0]        clean_flags;
  logic                     frag0_clean;

  assign alloc_ok   = alloc_valid && (alloc_nfrag != '0) && (alloc_nfrag <= CNT_W'(NFRAG));
  assign alloc_bad  = alloc_valid && !alloc_ok;
  assign done_ok    = done_valid && !alloc_valid && (state == ST_XLATE) &&
                      (CNT_W'(done_idx) < nfrag_q) && !slot_filled[done_idx];
  assign done_bad   = done_valid && !alloc_valid && !done_ok;
  assign last_done  = done_ok && (in_xlate_cnt == CNT_W'(1));
  assign resolve_ev = fin_q && !alloc_valid;
  assign mem_ret_ev = mem_ret_valid && !alloc_valid && is_outcome(state);
  assign frag0_clean = (slot_fault[FAULT_W-1:0] == '0);

  for (genvar g = 0; g < NFRAG; g++) begin : g_slot
    frag_slot #(.FAULT_W(FAULT_W), .FLAG_W(FLAG_W), .PA_W(PA_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .clear(alloc_ok),
      .wr_en(done_ok && (done_idx == IDX_W'(g))),
      .fault_in(done_fault), .flags_in(done_flags), .pa_in(done_paddr),
      .filled(slot_filled[g]),
      .fault_q(slot_fault[g*FAULT_W +: FAULT_W]),
      .flags_q(slot_flags[g*FLAG_W +: FLAG_W]),
      .pa_q(slot_pa[g*PA_W +: PA_W]));
  end

  fault_resolver #(.NFRAG(NFRAG), .FAULT_W(FAULT_W), .FLAG_W(FLAG_W), .IDX_W(IDX_W)) u_res (
    .filled(slot_filled), .fault_vec(slot_fault), .flags_vec(slot_flags),
    .any_fault(any_fault), .first_idx(first_idx), .first_code(first_code),
    .clean_flags(clean_flags));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      nfrag_q      <= '0;
      is_load_q    <= 1'b0;
      cswap_q      <= 1'b0;
      squashed_q   <= 1'b0;
      fin_q        <= 1'b0;
      acc_done_q   <= 1'b0;
      fault_q      <= '0;
      base_paddr   <= '0;
      merged_flags <= '0;
      in_xlate_cnt <= '0;
      xlated_cnt   <= '0;
      err_o        <= 1'b0;
    end else if (alloc_ok) begin
      state        <= ST_XLATE;
      nfrag_q      <= alloc_nfrag;
      is_load_q    <= alloc_is_load;
      cswap_q      <= alloc_cswap;
      squashed_q   <= 1'b0;
      fin_q        <= 1'b0;
      acc_done_q   <= 1'b0;
      fault_q      <= '0;
      base_paddr   <= '0;
      merged_flags <= '0;
      in_xlate_cnt <= alloc_nfrag;
      xlated_cnt   <= '0;
      err_o        <= 1'b0;
    end else begin
      if (alloc_bad || done_bad) err_o <= 1'b1;
      fin_q <= last_done;
      if (done_ok) begin
        in_xlate_cnt <= in_xlate_cnt - CNT_W'(1);
        xlated_cnt   <= xlated_cnt + CNT_W'(1);
      end
      if (resolve_ev && !squashed_q && !squash) begin
        if (frag0_clean) begin
          base_paddr   <= slot_pa[PA_W-1:0];
          merged_flags <= clean_flags;
        end
        if (!any_fault) begin
          state   <= ST_REQUEST;
          fault_q <= '0;
        end else if (first_idx == '0) begin
          state   <= ST_FAULT;
          fault_q <= first_code;
        end else begin
          state   <= ST_PARTIAL;
          fault_q <= first_code;
          if (cswap_q) err_o <= 1'b1;
        end
      end else if (resolve_ev) begin
        state <= ST_SQUASHED;
      end
      if (mem_ret_ev) begin
        if (mem_ret_fault != '0) fault_q <= mem_ret_fault;
        if (!mem_ret_blocked) acc_done_q <= 1'b1;
      end
      if (squash && state != ST_IDLE) begin
        squashed_q <= 1'b1;
        if (state != ST_XLATE) begin
          state        <= ST_SQUASHED;
          fault_q      <= '0;
          base_paddr   <= '0;
          merged_flags <= '0;
        end
      end
    end
  end

  assign state_o        = state;
  assign xlate_done     = is_outcome(state) || (state == ST_SQUASHED);
  assign replay_o       = (state == ST_PARTIAL) && is_load_q && !acc_done_q;
  assign fault_o        = replay_o ? '0 : fault_q;
  assign mem_access_req = ((state == ST_REQUEST) || ((state == ST_PARTIAL) && is_load_q)) &&
                          !acc_done_q;

  // R2: counters always account for every fragment while translating
  assert_cnt_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_XLATE) |-> (in_xlate_cnt + xlated_cnt == nfrag_q));
  // R4: squashed outcome exposes nothing
  assert_squash_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SQUASHED) |-> (fault_o == '0 && !mem_access_req));
  // R5: fault on fragment 0 gives the full-fault state
  assert_frag0_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_ev && !squashed_q && !squash && !frag0_clean) |=> (state == ST_FAULT));
  // R8: a store with a partial fault never touches memory
  assert_store_noacc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PARTIAL && !is_load_q) |-> !mem_access_req);
  // R10: a null return keeps the stored fault
  assert_keep_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ret_ev && mem_ret_fault == '0 && !squash) |=> $stable(fault_q));
  // R11: a pending replay hides the fault
  assert_replay_hides_R11: assert property (@(posedge clk) disable iff (!rst_n)
    replay_o |-> (fault_o == '0 && mem_access_req));
endmodule

// File: tb/split_xlate_agg_test.sv
module split_xlate_agg_test;
  localparam int NF = 4;
  localparam int FW = 4, LW = 4, PW = 16;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, alloc_is_load = 0, alloc_cswap = 0, squash = 0;
  logic [2:0] alloc_nfrag = 0;
  logic done_valid = 0;
  logic [1:0] done_idx = 0;
  logic [FW-1:0] done_fault = 0;
  logic [LW-1:0] done_flags = 0;
  logic [PW-1:0] done_paddr = 0;
  logic mem_ret_valid = 0, mem_ret_blocked = 0;
  logic [FW-1:0] mem_ret_fault = 0;
  logic [2:0] state_o;
  logic xlate_done, mem_access_req, replay_o, err_o;
  logic [FW-1:0] fault_o;
  logic [PW-1:0] base_paddr;
  logic [LW-1:0] merged_flags;
  logic [2:0] in_xlate_cnt, xlated_cnt;

  int checks = 0, failures = 0;

  split_xlate_agg #(.NFRAG(NF), .FAULT_W(FW), .FLAG_W(LW), .PA_W(PW)) uut (.*);

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] code_of(int i); return FW'(i + 3); endfunction
  function automatic logic [PW-1:0] pa_of(int i); return PW'(16'h1000 + i * 16'h0140); endfunction

  task automatic alloc(int nf, bit ld, bit cs);
    @(negedge clk); alloc_valid = 1; alloc_nfrag = 3'(nf); alloc_is_load = ld; alloc_cswap = cs;
    @(negedge clk); alloc_valid = 0;
  endtask

  task automatic send(int i, logic [FW-1:0] f);
    done_valid = 1; done_idx = 2'(i); done_fault = f;
    done_flags = LW'(1 << i); done_paddr = pa_of(i);
    @(negedge clk); done_valid = 0;
  endtask

  task automatic memret(logic [FW-1:0] f, bit blk);
    mem_ret_valid = 1; mem_ret_fault = f; mem_ret_blocked = blk;
    @(negedge clk); mem_ret_valid = 0;
  endtask

  task automatic run(int nf, int mask, bit ld, bit rev);
    int first = -1;
    logic [LW-1:0] fl = 0;
    int st;
    alloc(nf, ld, 0);
    for (int k = 0; k < nf; k++) begin
      int i = rev ? nf - 1 - k : k;
      send(i, mask[i] ? code_of(i) : '0);
    end
    @(negedge clk);
    for (int i = nf - 1; i >= 0; i--) if (mask[i]) first = i;
    for (int i = 0; i < nf; i++) if (!mask[i]) fl |= LW'(1 << i);
    st = (first < 0) ? 2 : (first == 0) ? 4 : 3;
    chk("R1/R6 state", state_o, st);
    chk("R2 in_xlate", in_xlate_cnt, 0);
    chk("R2 xlated", xlated_cnt, nf);
    chk("R6 xlate_done", xlate_done, 1);
    chk("R3/R7 flags", merged_flags, mask[0] ? 0 : fl);
    chk("R5/R7 base", base_paddr, mask[0] ? 0 : pa_of(0));
    chk("R8 memreq", mem_access_req, (st == 2) || (st == 3 && ld));
    chk("R11 replay", replay_o, st == 3 && ld);
    if (st == 2) chk("R6 fault none", fault_o, 0);
    else if (st == 4) chk("R5 fault", fault_o, code_of(0));
    else chk("R6/R11 fault", fault_o, ld ? 0 : code_of(first));
    chk("R12 err", err_o, 0);
    if (st == 3 && ld) begin
      memret(0, 1);
      chk("R11 still replay", replay_o, 1);
      chk("R11 still hidden", fault_o, 0);
      memret(0, 0);
      chk("R10/R11 deferred fault", fault_o, code_of(first));
      chk("R11 replay cleared", replay_o, 0);
      chk("R8 memreq done", mem_access_req, 0);
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset state", state_o, 0);
    chk("R12 reset fault", fault_o, 0);
    chk("R12 reset memreq", mem_access_req, 0);
    rst_n = 1;
    @(negedge clk);
    // R12: completion while idle
    send(0, 0);
    chk("R12 stray done", err_o, 1);
    chk("R12 stray no count", xlated_cnt, 0);

    for (int nf = 1; nf <= NF; nf++)
      for (int m = 0; m < (1 << nf); m++)
        for (int ld = 0; ld < 2; ld++)
          for (int rv = 0; rv < 2; rv++) run(nf, m, ld[0], rv[0]);

    // R2: counters mid-translation
    alloc(3, 1, 0);
    send(2, 0);
    chk("R2 mid in", in_xlate_cnt, 2);
    chk("R2 mid done", xlated_cnt, 1);
    // R12: out-of-range and repeated index
    send(3, 0);
    chk("R12 out of range", err_o, 1);
    send(2, 0);
    chk("R12 repeat count", xlated_cnt, 1);
    // R4: squash during translation
    squash = 1; @(negedge clk); squash = 0;
    send(0, 0); send(1, 0);
    @(negedge clk);
    chk("R4 squashed state", state_o, 5);
    chk("R4 squashed fault", fault_o, 0);
    chk("R4 squashed memreq", mem_access_req, 0);

    // R9: conditional swap ending in partial fault
    alloc(2, 1, 1);
    send(0, 0); send(1, 4'h6);
    @(negedge clk);
    chk("R9 cswap partial err", err_o, 1);
    alloc(2, 1, 1);
    send(1, 0); send(0, 0);
    @(negedge clk);
    chk("R9 cswap clean no err", err_o, 0);
    // R10: non-zero return replaces
    memret(4'h9, 0);
    chk("R10 replaced fault", fault_o, 4'h9);
    chk("R8 memreq after completion", mem_access_req, 0);
    // R12: bad allocation count
    alloc(0, 0, 0);
    chk("R12 bad alloc", err_o, 1);
    chk("R12 bad alloc keeps state", state_o, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule